// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Controller

This block is the slave-side protocol engine of a serial memory on a two-wire bus. A fast system clock oversamples SCL and SDA. After synchronizing both lines, the block detects START and STOP conditions and shifts in a select byte. It accepts the byte when the byte carries the memory type code and matches three strap inputs. The block acknowledges by pulling SDA low through an open-drain enable. It supports byte and page writes, current-address reads, random reads (a dummy write of the address followed by a repeated START) and sequential reads.

Array access goes through a simple synchronous port. Each received data byte becomes one write strobe. A read request returns its data one cycle later. An address counter keeps its value between transactions and wraps at the top of the array. When a write ends with a STOP, the block hands the completed write to an external programming block. While that block reports that it is busy, the slave ignores the bus.

Top module: `eeprom_i2c_slave`

## Requirements
- R1: A START (SDA falling while SCL is high) followed by the select byte `1010` (bits 7..4), the strap value in bits 3..1 and R/W in bit 0 (1 = read) is acknowledged: `sda_oe_o` is high while SCL is high in the 9th clock.
- R2: If the type code or the strap value does not match, the byte is not acknowledged and later bytes get no acknowledge and cause no array writes until the next START.
- R3: After a write select byte, two address bytes are received, upper byte first, and each is acknowledged. Address bits above ADDR_W-1 are ignored (with ADDR_W = 13, bits 15..13 are ignored).
- R4: Each data byte received after the address bytes is acknowledged and produces exactly one `mem_we_o` strobe. The first strobe uses the loaded address and each later strobe uses the next address.
- R5: A STOP after at least one data byte pulses `prog_start_o` for one clock. A STOP after only a select byte or address bytes does not.
- R6: A read select byte without a preceding address returns the byte at the current address counter. The counter keeps its value across transactions, including a value loaded by an address-only write.
- R7: A random read (address write, then repeated START with a read select byte) returns the byte at the written address.
- R8: In a read, after the master acknowledges a byte, the next byte comes from the next address. The counter wraps from 2^ADDR_W-1 to 0.
- R9: After the master NoAcks a read byte, the slave releases SDA and drives nothing more until the next START.
- R10: While `busy_i` is high, a START is ignored and no select byte is acknowledged.
- R11: A START in the middle of any byte aborts the transfer and restarts select-byte reception.
- R12: Read bytes are sent most significant bit first. `sda_oe_o` changes only while SCL is low.
- R13: After reset, SDA is released, no strobes are active and the address counter is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock (oversamples the bus) |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line (wired value) |
| sda_oe_o | output | 1 | High pulls SDA low |
| chip_en_i | input | 3 | Strap value compared with select bits 3..1 |
| busy_i | input | 1 | Programming cycle in progress; bus ignored |
| mem_addr_o | output | ADDR_W | Array address (address counter) |
| mem_wdata_o | output | 8 | Write data |
| mem_we_o | output | 1 | One-cycle write strobe |
| mem_re_o | output | 1 | Read request; data expected the next cycle |
| mem_rdata_i | input | 8 | Read data, valid one cycle after `mem_re_o` |
| prog_start_o | output | 1 | One-cycle pulse: write transaction complete |

## Verification
The counter wrap at the top of the array is the hardest case to reach. Only a sequential read that crosses address 2^ADDR_W-1 shows it. The stimulus gets there with a dummy write of 0xFFFF, whose ignored upper bits also test the address masking, then a repeated START and a two-byte read. The busy lockout and the mid-byte abort are reached by driving the bus directly: a START arrives while `busy_i` is high, and another START is forced four bits into an address byte. The result is then observed through the acknowledge slots and the array strobes.

// File: rtl/eep_pkg.sv
package eep_pkg;
  localparam int BYTE_W = 8;
  localparam int CE_W = 3;
  localparam logic [3:0] TYPE_CODE = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_AHI,
    ST_ALO,
    ST_WDATA,
    ST_RACK,
    ST_RDATA
  } eep_state_e;
endpackage

// File: rtl/eep_bus_sync.sv
module eep_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic start_o,
  output logic stop_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] scl_q, sda_q;
  logic scl_d, sda_d, scl_s, sda_s;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        scl_q[i] <= 1'b1;
        sda_q[i] <= 1'b1;
      end else if (i == 0) begin
        scl_q[i] <= scl_i;
        sda_q[i] <= sda_i;
      end else begin
        scl_q[i] <= scl_q[(i == 0) ? 0 : i-1];
        sda_q[i] <= sda_q[(i == 0) ? 0 : i-1];
      end
    end
  end

  assign scl_s = scl_q[STAGES-1];
  assign sda_s = sda_q[STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  assign sda_o   = sda_s;
  assign start_o = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_o  = scl_s & scl_d & ~sda_d & sda_s;
  assign rise_o  = scl_s & ~scl_d;
  assign fall_o  = ~scl_s & scl_d;
endmodule

// File: rtl/eep_addr_ctr.sv
module eep_addr_ctr #(
  parameter int ADDR_W = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_i,
  input  logic [15:0]       ld_val_i,
  input  logic              inc_i,
  output logic [ADDR_W-1:0] addr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     addr_o <= '0;
    else if (ld_i)   addr_o <= ld_val_i[ADDR_W-1:0];
    else if (inc_i)  addr_o <= addr_o + 1'b1;  // natural wrap at array top
  end
endmodule

// File: rtl/eep_ctrl.sv
module eep_ctrl
  import eep_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              sda_i,
  input  logic              busy_i,
  input  logic [CE_W-1:0]   chip_en_i,
  input  logic [BYTE_W-1:0] mem_rdata_i,
  output logic              sda_oe_o,
  output logic              we_o,
  output logic [BYTE_W-1:0] wdata_o,
  output logic              re_o,
  output logic              inc_o,
  output logic              ld_o,
  output logic [15:0]       ld_val_o,
  output logic              prog_o,
  output logic              idle_o
);
  eep_state_e        state_q;
  logic [3:0]        cnt_q;
  logic [BYTE_W-1:0] sh_q, tx_q, hi_q, wdata_q;
  logic              ack_q, tx_en_q, wr_any_q, mack_q;
  logic              we_q, re_q, rvalid_q, inc_q, ld_q, prog_q;
  logic              sel_ok;

  assign sel_ok = (sh_q[7:4] == TYPE_CODE) && (sh_q[3:1] == chip_en_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      sh_q     <= '0;
      tx_q     <= '0;
      hi_q     <= '0;
      wdata_q  <= '0;
      ack_q    <= 1'b0;
      tx_en_q  <= 1'b0;
      wr_any_q <= 1'b0;
      mack_q   <= 1'b0;
      we_q     <= 1'b0;
      re_q     <= 1'b0;
      rvalid_q <= 1'b0;
      inc_q    <= 1'b0;
      ld_q     <= 1'b0;
      prog_q   <= 1'b0;
    end else begin
      we_q     <= 1'b0;
      re_q     <= 1'b0;
      inc_q    <= 1'b0;
      ld_q     <= 1'b0;
      prog_q   <= 1'b0;
      rvalid_q <= re_q;
      if (rvalid_q) tx_q <= mem_rdata_i;

      if (start_i && !busy_i) begin
        state_q  <= ST_DEV;
        cnt_q    <= '0;
        ack_q    <= 1'b0;
        tx_en_q  <= 1'b0;
        wr_any_q <= 1'b0;
      end else if (stop_i) begin
        if (state_q == ST_WDATA && wr_any_q) prog_q <= 1'b1;
        state_q  <= ST_IDLE;
        cnt_q    <= '0;
        ack_q    <= 1'b0;
        tx_en_q  <= 1'b0;
        wr_any_q <= 1'b0;
      end else if (state_q != ST_IDLE) begin
        if (rise_i) begin
          if (cnt_q < 4'd8) begin
            sh_q  <= {sh_q[BYTE_W-2:0], sda_i};
            cnt_q <= cnt_q + 4'd1;
          end else if (cnt_q == 4'd9 && state_q == ST_RDATA) begin
            mack_q <= ~sda_i;
            if (!sda_i) re_q <= 1'b1;  // prefetch next byte
          end
        end
        if (fall_i) begin
          if (cnt_q == 4'd8) begin
            cnt_q <= 4'd9;
            unique case (state_q)
              ST_DEV: begin
                if (sel_ok) begin
                  ack_q <= 1'b1;
                  if (sh_q[0]) begin
                    state_q <= ST_RACK;
                    re_q    <= 1'b1;
                  end else begin
                    state_q <= ST_AHI;
                  end
                end else begin
                  state_q <= ST_IDLE;
                end
              end
              ST_AHI: begin
                hi_q    <= sh_q;
                ack_q   <= 1'b1;
                state_q <= ST_ALO;
              end
              ST_ALO: begin
                ld_q    <= 1'b1;
                ack_q   <= 1'b1;
                state_q <= ST_WDATA;
              end
              ST_WDATA: begin
                we_q     <= 1'b1;
                wdata_q  <= sh_q;
                wr_any_q <= 1'b1;
                ack_q    <= 1'b1;
              end
              ST_RDATA: begin
                tx_en_q <= 1'b0;
                inc_q   <= 1'b1;
              end
              default: ;
            endcase
          end else if (cnt_q == 4'd9) begin
            cnt_q <= '0;
            ack_q <= 1'b0;
            if (state_q == ST_RACK) begin
              state_q <= ST_RDATA;
              tx_en_q <= 1'b1;
            end else if (state_q == ST_RDATA) begin
              if (mack_q) tx_en_q <= 1'b1;
              else        state_q <= ST_IDLE;
            end
          end else if (state_q == ST_RDATA && cnt_q != 4'd0) begin
            tx_q <= {tx_q[BYTE_W-2:0], 1'b0};
          end
        end
      end
    end
  end

  assign sda_oe_o = ack_q | (tx_en_q & ~tx_q[BYTE_W-1]);
  assign we_o     = we_q;
  assign wdata_o  = wdata_q;
  assign re_o     = re_q;
  assign inc_o    = inc_q;
  assign ld_o     = ld_q;
  assign ld_val_o = {hi_q, sh_q};
  assign prog_o   = prog_q;
  assign idle_o   = (state_q == ST_IDLE);
endmodule

// File: rtl/eeprom_i2c_slave.sv
module eeprom_i2c_slave
  import eep_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic [2:0]        chip_en_i,
  input  logic              busy_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [7:0]        mem_wdata_o,
  output logic              mem_we_o,
  output logic              mem_re_o,
  input  logic [7:0]        mem_rdata_i,
  output logic              prog_start_o
);
  logic        sda_s, start_p, stop_p, rise_p, fall_p;
  logic        inc_rd, ld, ctrl_idle;
  logic [15:0] ld_val;

  eep_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .sda_o(sda_s), .start_o(start_p), .stop_o(stop_p),
    .rise_o(rise_p), .fall_o(fall_p)
  );

  eep_ctrl u_ctrl (
    .clk_i, .rst_ni,
    .start_i(start_p), .stop_i(stop_p), .rise_i(rise_p), .fall_i(fall_p),
    .sda_i(sda_s), .busy_i, .chip_en_i, .mem_rdata_i,
    .sda_oe_o, .we_o(mem_we_o), .wdata_o(mem_wdata_o), .re_o(mem_re_o),
    .inc_o(inc_rd), .ld_o(ld), .ld_val_o(ld_val), .prog_o(prog_start_o),
    .idle_o(ctrl_idle)
  );

  eep_addr_ctr #(.ADDR_W(ADDR_W)) u_addr (
    .clk_i, .rst_ni,
    .ld_i(ld), .ld_val_i(ld_val),
    .inc_i(inc_rd | mem_we_o),
    .addr_o(mem_addr_o)
  );
endmodule

// File: rtl/eep_checker.sv
module eep_checker #(
  parameter int ADDR_W = 13
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              scl_i,
  input logic              sda_oe_o,
  input logic              busy_i,
  input logic              idle_i,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_we_o,
  input logic              mem_re_o,
  input logic              prog_start_o
);
  p_oe_scl_low_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> !scl_i);

  p_busy_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && idle_i) |=> idle_i);

  p_we_acked_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> sda_oe_o);

  p_we_next_addr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> (mem_addr_o == ADDR_W'($past(mem_addr_o) + 1'b1)));

  p_prog_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_start_o |=> !prog_start_o);

  p_rw_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_we_o && mem_re_o));
endmodule

bind eeprom_i2c_slave eep_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i, .rst_ni, .scl_i, .sda_oe_o, .busy_i,
  .idle_i(ctrl_idle), .mem_addr_o, .mem_we_o, .mem_re_o, .prog_start_o
);

// File: tb/sim_eeprom_i2c_slave.sv
`timescale 1ns/1ps
module sim_eeprom_i2c_slave;
  localparam int ADDR_W = 13;
  localparam int Q = 8;
  localparam logic [7:0] DEV_WR = 8'hAA;  // 1010_101_0
  localparam logic [7:0] DEV_RD = 8'hAB;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, busy_m = 1'b0;
  logic sda_w, sda_oe, mem_we, mem_re, prog;
  logic [ADDR_W-1:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;
  logic [7:0] mem_m [int];
  int n_chk = 0, n_bad = 0, n_prog = 0, n_wr = 0, n_oe_hi_chg = 0;
  logic prev_oe = 1'b0;
  logic done = 1'b0;

  always #2 clk = ~clk;

  assign sda_w = sda_m & ~sda_oe;

  eeprom_i2c_slave #(.ADDR_W(ADDR_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_w),
    .sda_oe_o(sda_oe), .chip_en_i(3'b101), .busy_i(busy_m),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_we_o(mem_we),
    .mem_re_o(mem_re), .mem_rdata_i(mem_rdata), .prog_start_o(prog)
  );

  function automatic logic [7:0] pat(input int a);
    return 8'(a) ^ 8'h5A;
  endfunction

  function automatic logic [7:0] rd_model(input int a);
    return mem_m.exists(a) ? mem_m[a] : pat(a);
  endfunction

  always @(posedge clk) if (mem_re) mem_rdata <= rd_model(int'(mem_addr));

  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_we) begin
        mem_m[int'(mem_addr)] = mem_wdata;
        n_wr++;
      end
      if (prog) n_prog++;
      if (scl_m && sda_oe != prev_oe) n_oe_hi_chg++;
    end
    prev_oe = sda_oe;
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic qw();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; qw(); scl_m = 1'b1; qw(); sda_m = 1'b0; qw(); scl_m = 1'b0; qw();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; qw(); scl_m = 1'b1; qw(); sda_m = 1'b1; qw();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; qw(); scl_m = 1'b1; qw(); scl_m = 1'b0; qw();
    end
    sda_m = 1'b1; qw(); scl_m = 1'b1; qw();
    ack = ~sda_w;
    scl_m = 1'b0; qw();
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] d);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      qw(); scl_m = 1'b1; qw(); d[i] = sda_w; scl_m = 1'b0;
    end
    qw(); sda_m = ~mack; qw(); scl_m = 1'b1; qw(); scl_m = 1'b0; qw(); sda_m = 1'b1;
  endtask

  task automatic set_addr(input logic [7:0] hi, input logic [7:0] lo, input string req);
    logic a;
    send_byte(DEV_WR, a); chk(a, "R1 write select ack", a, 1);
    send_byte(hi, a);     chk(a, req, a, 1);
    send_byte(lo, a);     chk(a, req, a, 1);
  endtask

  task automatic t_reset();
    logic a; logic [7:0] d;
    chk(!sda_oe && !mem_we && !mem_re && !prog, "R13 reset outputs", {sda_oe, mem_we, mem_re, prog}, 0);
    bus_start();
    send_byte(DEV_RD, a); chk(a, "R1 read select ack", a, 1);
    recv_byte(1'b0, d);   chk(d == pat(0), "R13 counter zero after reset", d, pat(0));
    bus_stop();
  endtask

  task automatic t_write();
    logic a; int w0 = n_wr, p0 = n_prog;
    bus_start();
    set_addr(8'hE1, 8'h20, "R3 address byte ack");
    send_byte(8'h11, a); chk(a, "R4 data ack", a, 1);
    send_byte(8'h22, a); chk(a, "R4 data ack", a, 1);
    send_byte(8'h33, a); chk(a, "R4 data ack", a, 1);
    bus_stop();
    chk(n_wr - w0 == 3, "R4 write strobes", n_wr - w0, 3);
    chk(mem_m.exists(32'h120) && mem_m[32'h120] == 8'h11, "R3 upper bits ignored", rd_model(32'h120), 8'h11);
    chk(rd_model(32'h121) == 8'h22 && rd_model(32'h122) == 8'h33, "R4 successive addresses",
        {rd_model(32'h121), rd_model(32'h122)}, 16'h2233);
    chk(n_prog - p0 == 1, "R5 prog pulse after data", n_prog - p0, 1);
  endtask

  task automatic t_current();
    logic a; logic [7:0] d;
    bus_start();
    send_byte(DEV_RD, a);
    recv_byte(1'b0, d); chk(d == pat(32'h123), "R6 current read after write", d, pat(32'h123));
    bus_stop();
  endtask

  task automatic t_addr_only();
    logic a; logic [7:0] d; int p0 = n_prog, w0 = n_wr;
    bus_start();
    set_addr(8'h03, 8'h00, "R3 address byte ack");
    bus_stop();
    chk(n_prog == p0 && n_wr == w0, "R5 no prog without data", n_prog - p0, 0);
    bus_start();
    send_byte(DEV_RD, a);
    recv_byte(1'b0, d); chk(d == pat(32'h300), "R6 counter kept from address write", d, pat(32'h300));
    bus_stop();
  endtask

  task automatic t_random_seq();
    logic a; logic [7:0] d;
    bus_start();
    set_addr(8'h01, 8'h20, "R7 address ack");
    bus_start();
    send_byte(DEV_RD, a); chk(a, "R7 repeated start select ack", a, 1);
    recv_byte(1'b1, d); chk(d == 8'h11, "R7 random read", d, 8'h11);
    recv_byte(1'b1, d); chk(d == 8'h22, "R8 sequential next", d, 8'h22);
    recv_byte(1'b0, d); chk(d == 8'h33, "R12 msb first sequential", d, 8'h33);
    recv_byte(1'b0, d); chk(d == 8'hFF, "R9 released after NoAck", d, 8'hFF);
    bus_stop();
  endtask

  task automatic t_wrap();
    logic a; logic [7:0] d;
    bus_start();
    set_addr(8'hFF, 8'hFF, "R3 address ack top");
    bus_start();
    send_byte(DEV_RD, a);
    recv_byte(1'b1, d); chk(d == pat(32'h1FFF), "R8 top byte", d, pat(32'h1FFF));
    recv_byte(1'b0, d); chk(d == pat(0), "R8 wrap to zero", d, pat(0));
    bus_stop();
  endtask

  task automatic t_mismatch();
    logic a; int w0 = n_wr;
    bus_start();
    send_byte(8'hA2, a); chk(!a, "R2 strap mismatch no ack", a, 0);
    send_byte(8'h00, a); chk(!a, "R2 ignored byte", a, 0);
    send_byte(8'h00, a);
    send_byte(8'h77, a); chk(!a, "R2 ignored data", a, 0);
    bus_stop();
    bus_start();
    send_byte(8'h2A, a); chk(!a, "R2 type mismatch no ack", a, 0);
    bus_stop();
    chk(n_wr == w0, "R2 no writes", n_wr - w0, 0);
  endtask

  task automatic t_busy();
    logic a;
    busy_m = 1'b1;
    bus_start();
    send_byte(DEV_WR, a); chk(!a, "R10 busy ignores start", a, 0);
    bus_stop();
    busy_m = 1'b0;
  endtask

  task automatic t_abort();
    logic a; int p0 = n_prog;
    bus_start();
    send_byte(DEV_WR, a);
    for (int i = 0; i < 4; i++) begin
      sda_m = 1'b0; qw(); scl_m = 1'b1; qw(); scl_m = 1'b0; qw();
    end
    bus_start();
    set_addr(8'h02, 8'h00, "R11 restarted address ack");
    send_byte(8'h44, a); chk(a, "R11 data ack after abort", a, 1);
    bus_stop();
    chk(rd_model(32'h200) == 8'h44, "R11 write after abort", rd_model(32'h200), 8'h44);
    chk(n_prog - p0 == 1, "R5 prog after restarted write", n_prog - p0, 1);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_write();
    t_current();
    t_addr_only();
    t_random_seq();
    t_wrap();
    t_mismatch();
    t_busy();
    t_abort();
    chk(n_oe_hi_chg == 0, "R12 sda drive changes only with SCL low", n_oe_hi_chg, 0);
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule